// File: doc/BRIEF.md
# Latched Polarity Interrupt Capture

This block watches eight external event inputs and turns each qualifying level into a status bit that the processor can read. It can then hold an interrupt request until software acknowledges it. Each channel can be configured three ways. An enable bit decides whether the channel's status reaches the interrupt line. A polarity bit decides whether a high or a low level counts as the event. A mode bit decides whether the status bit is sticky or simply follows the qualified level.

Every input passes through a two-flop synchronizer before it is qualified, so the inputs may be asynchronous to the clock. Software works through a small 32-bit register port, with a one-cycle write strobe and a combinational read. The port gives access to the enable, polarity and mode settings, the raw status, the masked status and a write-one-to-clear acknowledge. The input pins themselves cannot be read. All interrupt reporting is level type: the single interrupt output stays high while any enabled channel holds a status bit.

Top module: `evt_latch_irq`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is 0.
- R2: The enable (offset 0x00), polarity (0x10) and mode (0x14) registers take bits 7:0 of a write and read them back. Bits 31:8 of these registers read 0.
- R3: In mode 0, a qualified event sets its raw status bit at offset 0x04. The bit stays set after the input returns to its inactive level, and it clears only when software acknowledges it.
- R4: Writing 1 to a bit at offset 0x0C clears that channel's raw bit on the next clock edge, provided the channel's input is inactive. Writing 0 to a bit has no effect on that channel. Offset 0x0C reads 0.
- R5: If a channel's qualified input is still active in the cycle a clear is written, its raw bit remains set.
- R6: A polarity bit of 0 treats a high input as the event, and a polarity bit of 1 treats a low input as the event. A change on an input pin reaches the raw status bit at the third rising clock edge after the change: two synchronizer stages plus the status flop.
- R7: In mode 1, the raw bit follows the synchronized qualified level. It sets while the input is active and drops one cycle after the input goes inactive, with no clear needed.
- R8: The masked status at offset 0x08 equals raw AND enable. `irq_out` is high exactly when the masked status is nonzero.
- R9: Reads of offsets 0x18 and 0x1C read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | External event inputs, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The assertions check, on every cycle, the rules that govern the status bits:
- a sticky bit holds unless a clear hits it;
- a clear of an inactive channel empties the bit;
- an active level always sets its bit;
- a mode-1 bit tracks the qualified level;
- the interrupt agrees with the masked status read back.

The bench scenarios are the only place several behaviours can be seen. These are the exact three-edge latency from pin to status, the polarity inversion, register readback with zeroed upper bits, and the inertness of unmapped offsets. The scenarios also cover random mixes of inputs, clears and configuration writes, which are compared against an independent cycle model.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W  = 5;
  localparam int BUS_W   = 32;
  localparam logic [ADDR_W-1:0] OFS_EN   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_POL  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h14;

  typedef enum logic {MODE_STICKY = 1'b0, MODE_FOLLOW = 1'b1} chan_mode_e;

  // Next value of one raw status bit.
  function automatic logic raw_next(chan_mode_e mode, logic act, logic clr, logic cur);
    if (mode == MODE_FOLLOW) return act;
    if (act)                 return 1'b1;
    if (clr)                 return 1'b0;
    return cur;
  endfunction

  // Qualified level: polarity 0 = active high, 1 = active low.
  function automatic logic qualify(logic lvl, logic pol);
    return lvl ^ pol;
  endfunction
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [N-1:0]      raw,
  input  logic [N-1:0]      msk,
  output logic [N-1:0]      en,
  output logic [N-1:0]      pol,
  output logic [N-1:0]      mode,
  output logic [N-1:0]      clr_hit,
  output logic [BUS_W-1:0]  rdata
);
  localparam int PAD = BUS_W - N;

  logic [N-1:0] wd;
  logic         unused_hi;
  assign wd        = wdata[N-1:0];
  assign unused_hi = ^wdata[BUS_W-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      pol  <= '0;
      mode <= '0;
    end else if (wr) begin
      if (addr == OFS_EN)   en   <= wd;
      if (addr == OFS_POL)  pol  <= wd;
      if (addr == OFS_MODE) mode <= wd;
    end
  end

  assign clr_hit = (wr && addr == OFS_CLR) ? wd : '0;

  always_comb begin
    unique case (addr)
      OFS_EN:   rdata = {{PAD{1'b0}}, en};
      OFS_RAW:  rdata = {{PAD{1'b0}}, raw};
      OFS_MSK:  rdata = {{PAD{1'b0}}, msk};
      OFS_POL:  rdata = {{PAD{1'b0}}, pol};
      OFS_MODE: rdata = {{PAD{1'b0}}, mode};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_latch.sv
module evt_latch
  import evt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] clr_hit,
  output logic [N-1:0] act,
  output logic [N-1:0] raw
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    assign act[i] = qualify(lvl[i], pol[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw[i] <= 1'b0;
      else        raw[i] <= raw_next(chan_mode_e'(mode[i]), act[i], clr_hit[i], raw[i]);
    end
  end
endmodule

// File: rtl/evt_latch_irq.sv
module evt_latch_irq
  import evt_pkg::*;
#(
  parameter int N         = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      evt_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_out
);
  logic [N-1:0] lvl_s;
  logic [N-1:0] act_vec;
  logic [N-1:0] raw_q;
  logic [N-1:0] msk_vec;
  logic [N-1:0] en_q;
  logic [N-1:0] pol_q;
  logic [N-1:0] mode_q;
  logic [N-1:0] clr_hit;

  evt_sync #(.N(N), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(evt_in), .q(lvl_s)
  );

  evt_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .pol(pol_q), .mode(mode_q),
    .clr_hit(clr_hit), .act(act_vec), .raw(raw_q)
  );

  assign msk_vec = raw_q & en_q;
  assign irq_out = |msk_vec;

  evt_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .raw(raw_q), .msk(msk_vec), .en(en_q), .pol(pol_q), .mode(mode_q),
    .clr_hit(clr_hit), .rdata(bus_rdata)
  );
endmodule

// File: rtl/evt_latch_irq_chk.sv
module evt_latch_irq_chk
  import evt_pkg::*;
#(
  parameter int N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      act,
  input logic [N-1:0]      raw,
  input logic [N-1:0]      mode,
  input logic [N-1:0]      clr,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  rdata,
  input logic              irq
);
  // R3: sticky bits hold unless a clear hits them
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(raw) & ~$past(mode) & ~$past(clr) & ~raw) == '0));

  // R4: a clear of an inactive sticky channel empties the bit
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr) & ~$past(act) & ~$past(mode) & raw) == '0));

  // R5: an active level always sets its bit, even with a clear
  a_r5_active_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(act) & ~raw) == '0));

  // R7: follow-mode bits track the qualified level
  a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(act) ^ raw) & $past(mode)) == '0));

  // R8: interrupt agrees with the masked status read back
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_MSK) |-> ((rdata != '0) == irq));
endmodule

bind evt_latch_irq evt_latch_irq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .act(act_vec), .raw(raw_q), .mode(mode_q),
  .clr(clr_hit), .addr(bus_addr), .rdata(bus_rdata), .irq(irq_out)
);

// File: tb/evt_latch_irq_bench.sv
module evt_latch_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_in = '0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_latch_irq u_evt_latch_irq (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // Independent cycle model built from the requirements
  logic [7:0] m_s1, m_s2, m_raw, m_en, m_pol, m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_raw <= '0; m_en <= '0; m_pol <= '0; m_mode <= '0;
    end else begin
      logic [7:0] nr;
      for (int i = 0; i < N; i++) begin
        logic a;
        a = (m_pol[i] == 1'b0) ? m_s2[i] : ~m_s2[i];
        if (m_mode[i])      nr[i] = a;
        else if (a)         nr[i] = 1'b1;
        else if (bus_wr && bus_addr == 5'h0C && bus_wdata[i]) nr[i] = 1'b0;
        else                nr[i] = m_raw[i];
      end
      m_raw <= nr;
      m_s1  <= evt_in;
      m_s2  <= m_s1;
      if (bus_wr && bus_addr == 5'h00) m_en   <= bus_wdata[7:0];
      if (bus_wr && bus_addr == 5'h10) m_pol  <= bus_wdata[7:0];
      if (bus_wr && bus_addr == 5'h14) m_mode <= bus_wdata[7:0];
    end
  end

  function automatic logic [31:0] exp_read(logic [4:0] a);
    case (a)
      5'h00: return {24'h0, m_en};
      5'h04: return {24'h0, m_raw};
      5'h08: return {24'h0, m_raw & m_en};
      5'h10: return {24'h0, m_pol};
      5'h14: return {24'h0, m_mode};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a)
      5'h04: return "R3";
      5'h08: return "R8";
      5'h0C: return "R4";
      5'h00, 5'h10, 5'h14: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare reads against the model
  task automatic cyc(logic [7:0] e, logic w, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    evt_in = e; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    chk(tag_of(a), bus_rdata, exp_read(a));
    chk("R8", {31'h0, irq_out}, {31'h0, |(m_raw & m_en)});
  endtask

  task automatic peek(logic [4:0] a, output logic [31:0] v);
    cyc(evt_in, 1'b0, a, 32'h0);
    v = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 32; a += 4) begin
      peek(a[4:0], v);
      chk("R1", v, 32'h0);
    end
    chk("R1", {31'h0, irq_out}, 32'h0);

    // R2: readback with upper bits zero
    cyc(8'h00, 1'b1, 5'h00, 32'hFFFF_FFA5);
    peek(5'h00, v); chk("R2", v, 32'h0000_00A5);
    cyc(8'h00, 1'b1, 5'h00, 32'h0000_00FF);

    // R6: three-edge latency, polarity 0 active high
    cyc(8'h01, 1'b0, 5'h04, 0);                    // drive before edge 1
    @(negedge clk); #1; chk("R6", bus_rdata, 32'h0); // after edge 1
    @(negedge clk); #1; chk("R6", bus_rdata, 32'h0); // after edge 2
    @(negedge clk); #1; chk("R6", bus_rdata, 32'h1); // after edge 3
    chk("R8", {31'h0, irq_out}, 32'h1);

    // R3: stays set after input goes inactive
    cyc(8'h00, 1'b0, 5'h04, 0);
    repeat (4) cyc(8'h00, 1'b0, 5'h04, 0);
    peek(5'h04, v); chk("R3", v, 32'h1);

    // R5: clear while active keeps the bit
    cyc(8'h02, 1'b0, 5'h04, 0);
    repeat (3) cyc(8'h02, 1'b0, 5'h04, 0);
    cyc(8'h02, 1'b1, 5'h0C, 32'h0000_0003);
    peek(5'h04, v); chk("R5", v, 32'h2);            // ch0 cleared, ch1 held
    peek(5'h0C, v); chk("R4", v, 32'h0);

    // R4: clear after inactive empties; zero bits no effect
    cyc(8'h00, 1'b0, 5'h04, 0);
    repeat (3) cyc(8'h00, 1'b0, 5'h04, 0);
    cyc(8'h00, 1'b1, 5'h0C, 32'h0000_0001);
    peek(5'h04, v); chk("R4", v, 32'h2);
    cyc(8'h00, 1'b1, 5'h0C, 32'h0000_0002);
    peek(5'h04, v); chk("R4", v, 32'h0);

    // R6: polarity 1 makes a low input the event
    cyc(8'hFF, 1'b0, 5'h04, 0);
    repeat (3) cyc(8'hFF, 1'b0, 5'h04, 0);
    cyc(8'hFF, 1'b1, 5'h10, 32'h0000_0010);
    cyc(8'hEF, 1'b1, 5'h0C, 32'h0000_00FF);
    repeat (3) cyc(8'hEF, 1'b0, 5'h04, 0);
    peek(5'h04, v); chk("R6", v & 32'h10, 32'h10);

    // R7: follow mode drops without a clear
    cyc(8'hEF, 1'b1, 5'h14, 32'h0000_0010);
    cyc(8'hFF, 1'b0, 5'h04, 0);
    repeat (3) cyc(8'hFF, 1'b0, 5'h04, 0);
    peek(5'h04, v); chk("R7", v & 32'h10, 32'h0);

    // R9: unmapped offsets ignore writes
    cyc(8'hFF, 1'b1, 5'h18, 32'hFFFF_FFFF);
    cyc(8'hFF, 1'b1, 5'h1C, 32'hFFFF_FFFF);
    peek(5'h18, v); chk("R9", v, 32'h0);
    peek(5'h14, v); chk("R9", v, 32'h10);

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] a;
      logic [7:0] e;
      logic w;
      a = 5'(($urandom % 8) * 4);
      w = ($urandom % 4) == 0;
      e = ($urandom % 3 == 0) ? 8'($urandom) : evt_in;
      cyc(e, w, a, $urandom);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule